// File: doc/BRIEF.md
# Framed Serial Client Shifter

This block is the serial engine of a framed SPI port running as a frame client. The serial clock is free-running and generated elsewhere. The block sees it as two single-cycle enables in the system clock domain: one for the transmit edge and one for the receive edge. The frame sync pin is driven by a remote frame master. When the block sees the sync pin go to its active level, it starts a burst of a programmed number of characters. Each character is 8, 16 or 32 bits long and is sent and received most significant bit first.

Transmit words come from a holding register on a valid/ready stream. `tx_ready` is high only in the cycle in which the engine loads a character, and a word passes when `tx_valid` and `tx_ready` are both high. That load happens whether or not the holding register has data. If the register is empty, the character goes out as zeros. Back-pressure is therefore one-sided: the source cannot stall the serial line, and a word that is late is skipped for that character. Received characters leave as a one-cycle strobe with no ready, because the line cannot be held.

A sync edge that arrives while a burst is still running is a frame error. It is recorded in a sticky flag and can raise an interrupt. It does not restart or stretch the burst. The flag is cleared by a write-one-to-clear pulse, or by disabling the block.

Top module: `framed_spi_client`

## Requirements
- R1: The sync pin is active when it equals `cfg_sync_pol` (1 = active high, 0 = active low). It is sampled on transmit edges, and a sync event is a sample at the active level whose previous sample was inactive.
- R2: The first bit of a frame appears on `sdo` after the transmit edge that follows the sync-sampling transmit edge. Bits go out most significant first, one per transmit edge.
- R3: Each character is loaded on a transmit edge, and `tx_ready` is high in exactly that cycle. If `tx_valid` is low then, the character is sent as all zeros.
- R4: `cfg_width` selects the character length: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. `sdi` is sampled on receive edges. After the last bit of each character, `rx_valid` pulses for one cycle with the character right-aligned in `rx_data` and the upper bits zero.
- R5: A frame holds `cfg_frame_chars + 1` characters, each loaded fresh from the holding register. After the last one, the block returns to idle and emits nothing more.
- R6: A sync event while a frame is pending or running sets `frm_err`. The frame still ends after its original character count.
- R7: A sync pulse that stays active over many transmit edges, for example one character wide, is a single event and causes no frame error.
- R8: `frm_err` stays set until a one-cycle `err_clr` pulse or until `enable` is low.
- R9: `err_irq` follows `frm_err` one cycle later, and only while `cfg_err_ie` is 1.
- R10: While `enable` is low, the block is idle: no frame starts, `rx_valid` and `frm_err` stay low, and `sdo` is 0.
- R11: `sdo` is 0 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| tx_edge | input | 1 | Serial clock transmit-edge enable |
| rx_edge | input | 1 | Serial clock receive-edge enable |
| fsync_in | input | 1 | Frame sync from the remote frame master |
| sdi | input | 1 | Serial data in |
| cfg_sync_pol | input | 1 | Active level of the sync pin |
| cfg_width | input | 2 | Character length select |
| cfg_frame_chars | input | FCW | Characters per frame minus one |
| cfg_err_ie | input | 1 | Frame-error interrupt enable |
| err_clr | input | 1 | Clears the frame-error flag |
| tx_valid | input | 1 | Holding register holds a word |
| tx_data | input | MAX_W | Holding register word, right-aligned |
| tx_ready | output | 1 | Character load in this cycle |
| sdo | output | 1 | Serial data out |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | MAX_W | Received character, right-aligned |
| frm_err | output | 1 | Sticky frame-error flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a second sync edge landing in the middle of a multi-character burst. Reaching it needs an inactive sample between two active ones while the character counter is neither at its start nor at its end. The bench gets there by timing the sync pin in system cycles against a fixed transmit-edge phase. A first one-edge pulse starts the frame, and a second pulse comes about ten transmit edges later, inside the second character. `sdo` is looped back to `sdi` with an optional inversion, so a frame that restarts or runs short shows up as a wrong received-word count.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_BUSY} fspi_state_e;

  function automatic int unsigned char_bits(input logic [1:0] sel, input int unsigned max_w);
    int unsigned b;
    case (sel)
      2'd0:    b = 8;
      2'd1:    b = 16;
      default: b = 32;
    endcase
    return (b > max_w) ? max_w : b;
  endfunction
endpackage

// File: rtl/fspi_sync_edge.sv
module fspi_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_edge,
  input  logic fsync_in,
  input  logic pol,
  output logic sync_evt
);
  logic act;
  logic prev_q;

  assign act = (fsync_in == pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (!enable) prev_q <= 1'b0;
    else if (tx_edge) prev_q <= act;
  end

  assign sync_evt = enable & tx_edge & act & ~prev_q;

  // R7: a held pulse yields one event only
  a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt);
endmodule

// File: rtl/fspi_shifter.sv
module fspi_shifter #(
  parameter int MAX_W = 32,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic             shift_tx,
  input  logic             shift_rx,
  input  logic             rx_clr,
  input  logic             line_clr,
  input  logic [MAX_W-1:0] load_data,
  input  logic [CW-1:0]    nbits,
  input  logic             sdi,
  output logic             sdo,
  output logic [MAX_W-1:0] rx_next
);
  localparam logic [CW-1:0] WMAX = CW'(MAX_W);

  logic [MAX_W-1:0] tx_sh;
  logic [MAX_W-1:0] rx_sh;
  logic [MAX_W-1:0] aligned;
  logic             sdo_q;

  assign aligned = load_data << (WMAX - nbits);
  assign rx_next = {rx_sh[MAX_W-2:0], sdi};
  assign sdo     = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
      tx_sh <= '0;
    end else if (!enable || line_clr) begin
      sdo_q <= 1'b0;
      tx_sh <= '0;
    end else if (load) begin
      sdo_q <= aligned[MAX_W-1];
      tx_sh <= aligned << 1;
    end else if (shift_tx) begin
      sdo_q <= tx_sh[MAX_W-1];
      tx_sh <= tx_sh << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_sh <= '0;
    else if (!enable)  rx_sh <= '0;
    else if (shift_rx) rx_sh <= rx_clr ? '0 : rx_next;
  end
endmodule

// File: rtl/framed_spi_client.sv
module framed_spi_client
  import fspi_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int FCW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_edge,
  input  logic             rx_edge,
  input  logic             fsync_in,
  input  logic             sdi,
  input  logic             cfg_sync_pol,
  input  logic [1:0]       cfg_width,
  input  logic [FCW-1:0]   cfg_frame_chars,
  input  logic             cfg_err_ie,
  input  logic             err_clr,
  input  logic             tx_valid,
  input  logic [MAX_W-1:0] tx_data,
  output logic             tx_ready,
  output logic             sdo,
  output logic             rx_valid,
  output logic [MAX_W-1:0] rx_data,
  output logic             frm_err,
  output logic             err_irq
);
  localparam int CW = $clog2(MAX_W + 1);

  fspi_state_e      state;
  logic [CW-1:0]    nbits;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [FCW-1:0]   tx_ch, rx_ch;
  logic             sync_evt;
  logic             in_busy, load_now, shift_now, rx_take, rx_word_end, frame_done, set_err;
  logic [MAX_W-1:0] rx_next;
  logic [MAX_W-1:0] load_word;

  assign nbits       = CW'(char_bits(cfg_width, MAX_W));
  assign in_busy     = (state == ST_BUSY);
  assign load_now    = tx_edge & ((state == ST_ARMED) |
                       (in_busy & (tx_cnt == nbits) & (tx_ch != cfg_frame_chars)));
  assign shift_now   = tx_edge & in_busy & (tx_cnt != nbits);
  assign rx_take     = rx_edge & in_busy;
  assign rx_word_end = rx_take & (rx_cnt == nbits - CW'(1));
  assign frame_done  = rx_word_end & (rx_ch == cfg_frame_chars);
  assign set_err     = sync_evt & (state != ST_IDLE);
  assign load_word   = tx_valid ? tx_data : '0;
  assign tx_ready    = load_now;

  fspi_sync_edge i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_edge  (tx_edge),
    .fsync_in (fsync_in),
    .pol      (cfg_sync_pol),
    .sync_evt (sync_evt)
  );

  fspi_shifter #(.MAX_W(MAX_W), .CW(CW)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load      (load_now),
    .shift_tx  (shift_now),
    .shift_rx  (rx_take),
    .rx_clr    (rx_word_end),
    .line_clr  (frame_done),
    .load_data (load_word),
    .nbits     (nbits),
    .sdi       (sdi),
    .sdo       (sdo),
    .rx_next   (rx_next)
  );

  // frame sequencing and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      tx_ch    <= '0;
      rx_ch    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      tx_ch    <= '0;
      rx_ch    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: if (sync_evt) begin
          state  <= ST_ARMED;
          rx_cnt <= '0;
          rx_ch  <= '0;
        end
        ST_ARMED: if (tx_edge) state <= ST_BUSY;
        ST_BUSY:  if (frame_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase

      if (load_now) begin
        tx_cnt <= CW'(1);
        tx_ch  <= (state == ST_ARMED) ? '0 : tx_ch + FCW'(1);
      end else if (shift_now) begin
        tx_cnt <= tx_cnt + CW'(1);
      end

      if (rx_word_end) begin
        rx_cnt   <= '0;
        rx_valid <= 1'b1;
        rx_data  <= rx_next;
        rx_ch    <= frame_done ? '0 : rx_ch + FCW'(1);
      end else if (rx_take) begin
        rx_cnt <= rx_cnt + CW'(1);
      end
    end
  end

  // error flag and interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_err <= 1'b0;
      err_irq <= 1'b0;
    end else if (!enable) begin
      frm_err <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      if (set_err)      frm_err <= 1'b1;
      else if (err_clr) frm_err <= 1'b0;
      err_irq <= frm_err & cfg_err_ie;
    end
  end

  // R11: line quiet outside a frame
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sdo);
  // R3: loads only on a transmit edge
  a_r3_ready_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_edge);
  // R6: an extra sync never re-arms a running frame
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busy && sync_evt && enable) |=> (state != ST_ARMED));
  // R8: flag holds without clear or disable
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && enable && !err_clr) |=> frm_err);
  // R9: interrupt only from an enabled flag
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(frm_err && cfg_err_ie));
  // R4: words only come out of a running frame
  a_r4_rx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(in_busy));
  // R10: disable empties everything
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rx_valid && !frm_err && state == ST_IDLE));
endmodule

// File: tb/test_framed_spi_client.sv
module test_framed_spi_client;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tx_edge = 1'b0, rx_edge = 1'b0;
  logic        fsync_in = 1'b0;
  logic        sdi;
  logic        cfg_sync_pol = 1'b1;
  logic [1:0]  cfg_width = 2'd0;
  logic [2:0]  cfg_frame_chars = 3'd0;
  logic        cfg_err_ie = 1'b0;
  logic        err_clr = 1'b0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, sdo, rx_valid, frm_err, err_irq;
  logic [31:0] rx_data;
  logic        inv = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int ph = 3;
  int tx_k = 0, rx_k = 0, nch = 0;
  logic        took = 1'b0;
  logic [31:0] dat_w [8];
  logic [31:0] exp_w [8];
  bit          vld_w [8];
  bit          done = 0;

  always #5 clk = ~clk;
  assign sdi = sdo ^ inv;

  framed_spi_client i_framed_spi_client (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_edge(tx_edge), .rx_edge(rx_edge),
    .fsync_in(fsync_in), .sdi(sdi), .cfg_sync_pol(cfg_sync_pol), .cfg_width(cfg_width),
    .cfg_frame_chars(cfg_frame_chars), .cfg_err_ie(cfg_err_ie), .err_clr(err_clr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .sdo(sdo),
    .rx_valid(rx_valid), .rx_data(rx_data), .frm_err(frm_err), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // edge generation, holding register source, receive monitor
  always begin
    @(negedge clk);
    ph = (ph + 1) % 4;
    tx_edge = (ph == 0);
    rx_edge = (ph == 2);
    if (took) tx_k++;
    tx_valid = (tx_k < 8) ? vld_w[tx_k] : 1'b0;
    tx_data  = dat_w[tx_k % 8];
    if (rx_valid) begin
      if (rx_k < nch) chk("R4 received word", rx_data, exp_w[rx_k]);
      else chk("R5 extra word", 32'd1, 32'd0);
      rx_k++;
    end
    #1 took = tx_ready;
  end

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  task automatic setup(input int w, input int chars, input logic [31:0] base, input int vm);
    for (int k = 0; k < 8; k++) begin
      dat_w[k] = base ^ (32'(k) * 32'h9E37_79B1);
      vld_w[k] = (k < chars) && vm[k];
      exp_w[k] = ((vld_w[k] ? dat_w[k] : 32'h0) ^ (inv ? 32'hFFFF_FFFF : 32'h0)) & wmask(w);
    end
    nch = chars; tx_k = 0; rx_k = 0;
  endtask

  task automatic pulse(input int cycles);
    @(negedge clk); fsync_in = cfg_sync_pol;
    repeat (cycles) @(negedge clk);
    fsync_in = ~cfg_sync_pol;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    setup(8, 0, 32'h0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset sdo", {31'd0, sdo}, 32'd0);
    chk("R10 reset flag", {31'd0, frm_err}, 32'd0);
    chk("R3 reset ready", {31'd0, tx_ready}, 32'd0);
    enable = 1'b1;

    // sweep width, frame length, polarity, inversion, empty-slot pattern
    for (int wsel = 0; wsel < 3; wsel++) begin
      for (int fc = 0; fc < 3; fc++) begin
        for (int p = 0; p < 2; p++) begin
          automatic int w = 8 << wsel;
          automatic int fi = wsel * 6 + fc * 2 + p;
          @(negedge clk);
          cfg_width = 2'(wsel); cfg_frame_chars = 3'(fc);
          cfg_sync_pol = p[0]; fsync_in = ~p[0]; inv = fi[0] ^ fi[2];
          setup(w, fc + 1, 32'hC3A5_5A3C + 32'(fi) * 32'h0101_1F1F, ~(1 << (fi % 4)));
          repeat (24) @(negedge clk);
          chk("R1 no start at inactive level", 32'(rx_k), 32'd0);
          pulse(4 * w);  // one character wide (R7)
          repeat (4 * w * (fc + 1) + 24) @(negedge clk);
          chk("R5 words per frame", 32'(rx_k), 32'(fc + 1));
          chk("R3 loads per frame", 32'(tx_k), 32'(fc + 1));
          chk("R11 sdo idle after frame", {31'd0, sdo}, 32'd0);
          chk("R7 wide pulse no error", {31'd0, frm_err}, 32'd0);
        end
      end
    end
    chk("R2 frame timing via loopback", 32'(n_bad), 32'd0);

    // mid-burst sync: error, no restart
    @(negedge clk);
    cfg_width = 2'd0; cfg_frame_chars = 3'd2; cfg_sync_pol = 1'b1; fsync_in = 1'b0; inv = 1'b0;
    cfg_err_ie = 1'b0;
    setup(8, 3, 32'h1234_5678, 7);
    repeat (8) @(negedge clk);
    pulse(4);
    repeat (40) @(negedge clk);
    pulse(4);
    repeat (200) @(negedge clk);
    chk("R6 error flagged", {31'd0, frm_err}, 32'd1);
    chk("R6 original count kept", 32'(rx_k), 32'd3);
    chk("R9 masked interrupt", {31'd0, err_irq}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R8 flag sticky", {31'd0, frm_err}, 32'd1);
    cfg_err_ie = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 enabled interrupt", {31'd0, err_irq}, 32'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 cleared by pulse", {31'd0, frm_err}, 32'd0);
    chk("R9 interrupt follows clear", {31'd0, err_irq}, 32'd0);

    // error again, then disable mid-frame
    setup(8, 3, 32'h0F0F_A0A0, 7);
    pulse(4);
    repeat (40) @(negedge clk);
    pulse(4);
    repeat (8) @(negedge clk);
    chk("R6 error again", {31'd0, frm_err}, 32'd1);
    enable = 1'b0;
    setup(8, 0, 32'h0, 0);
    repeat (2) @(negedge clk);
    chk("R10 flag cleared by disable", {31'd0, frm_err}, 32'd0);
    chk("R10 sdo quiet", {31'd0, sdo}, 32'd0);
    pulse(4);
    repeat (150) @(negedge clk);
    chk("R10 no frame while disabled", 32'(rx_k), 32'd0);
    chk("R10 no load while disabled", 32'(tx_k), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule